// File: doc/BRIEF.md
# Smart card ETU timing generator

This block sets the bit period for an asynchronous smart card serial link. It counts card clock cycles, marked by a clock enable, and raises a one-cycle pulse at the end of each elementary time unit (ETU). It raises a second one-cycle pulse halfway through each ETU, which the receive logic uses to sample in mid-bit. The ETU length is an 8-bit divider value multiplied by a prescaler of 31 or 32. A half-length mode halves that product, but only when the card clock does not come straight from the crystal.

The settings are taken in only at an ETU boundary, so rewriting them never cuts a running bit period short. A restart input clears the count, so the receive logic can line the first ETU up with a detected start-bit edge. A divider of zero parks the counter, and the block gives no pulses.

Top module: `etu_timer`

## Requirements
- R1: After reset both tick outputs are low and the timer is idle.
- R2: With the half mode off, the ETU lasts P × D enabled card clock cycles, where D is `divider` and P is 32 when `psc_sel` = 1 and 31 when `psc_sel` = 0.
- R3: With `half_mode` = 1 and `clk_is_xtal` = 0, the ETU lasts floor(P × D / 2) enabled cycles.
- R4: With `clk_is_xtal` = 1, `half_mode` has no effect and the ETU lasts the full P × D cycles.
- R5: While the loaded length is zero (divider 0), neither tick fires.
- R6: A change of divider or mode while the timer runs takes effect only after the current ETU ends. When the timer is idle, a new nonzero setting takes effect at the next clock edge, and the count starts from zero.
- R7: A high `restart` clears the count and loads the present settings at the next edge. No tick fires in a cycle where `restart` is high.
- R8: `half_tick` fires in the enabled cycle in which floor(L/2) cycles of the current ETU of length L have elapsed, counting that cycle. It never fires when floor(L/2) is 0.
- R9: The count advances only in cycles with `clk_en` high. Ticks fire only in such cycles.
- R10: `etu_tick` and `half_tick` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | One card clock cycle elapses in this clock cycle |
| restart | input | 1 | Clear the count and load the current settings |
| divider | input | 8 | Programmable divider value D |
| psc_sel | input | 1 | Prescaler select: 1 gives 32, 0 gives 31 |
| half_mode | input | 1 | Request a half-length ETU |
| clk_is_xtal | input | 1 | Card clock equals crystal clock; disables the half mode |
| etu_tick | output | 1 | One-cycle pulse in the last cycle of each ETU |
| half_tick | output | 1 | One-cycle pulse at the midpoint of each ETU |

## Verification
The hardest case to reach is a settings change that lands in the middle of a running ETU. The old length has to finish exactly, and the new one has to start exactly at the boundary. The stimulus rewrites the divider ten cycles into a period and then expects one period at the old length followed by periods at the new one. Freezing the enable for a fixed stretch in mid-period checks that the whole tick schedule slips by exactly that stretch. Restarting partway through a period checks that the pulses due from the abandoned period never appear.

// File: rtl/etu_timer.sv
module etu_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             restart,
  input  logic [DIV_W-1:0] divider,
  input  logic             psc_sel,
  input  logic             half_mode,
  input  logic             clk_is_xtal,
  output logic             etu_tick,
  output logic             half_tick
);
  localparam int LEN_W = DIV_W + 5;

  logic [LEN_W-1:0] div_ext, full_len, next_len, len_q, cnt_q, mid_pt;
  logic running, at_end, at_mid, fire_ok;

  assign div_ext  = LEN_W'(divider);
  assign full_len = psc_sel ? (div_ext << 5) : ((div_ext << 5) - div_ext);
  assign next_len = (half_mode && !clk_is_xtal) ? (full_len >> 1) : full_len;

  assign running = (len_q != '0);
  assign mid_pt  = len_q >> 1;
  assign at_end  = running && (cnt_q == len_q - 1'b1);
  assign at_mid  = running && (mid_pt != '0) && (cnt_q == mid_pt - 1'b1);
  assign fire_ok = clk_en && !restart;

  assign etu_tick  = fire_ok && at_end;
  assign half_tick = fire_ok && at_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (restart || !running) begin
      cnt_q <= '0;
      len_q <= next_len;
    end else if (clk_en) begin
      if (at_end) begin
        cnt_q <= '0;
        len_q <= next_len;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(etu_tick && half_tick));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !etu_tick && !half_tick);
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt_q < len_q);
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
  a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !clk_en && !restart) |=> $stable(cnt_q) && $stable(len_q));
  a_r6_len_held_mid_etu: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !restart && !etu_tick) |=> $stable(len_q));
  a_r9_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (etu_tick || half_tick) |-> clk_en);
endmodule

// File: tb/etu_timer_test.sv
module etu_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, clk_en = 1, restart = 0;
  logic [7:0] divider = 0;
  logic psc_sel = 0, half_mode = 0, clk_is_xtal = 0;
  logic etu_tick, half_tick;

  int cyc = 0, checks = 0, fails = 0, ticks_seen = 0;
  int base = 0, cur_len = 0;
  int q_cyc[$];
  bit q_etu[$];
  string q_req[$];
  bit done = 0;

  etu_timer uut (.clk(clk), .rst_n(rst_n), .clk_en(clk_en), .restart(restart),
    .divider(divider), .psc_sel(psc_sel), .half_mode(half_mode),
    .clk_is_xtal(clk_is_xtal), .etu_tick(etu_tick), .half_tick(half_tick));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int etu_len(int d, bit p, bit h, bit x);
    int l = (p ? 32 : 31) * d;
    if (h && !x) l = l / 2;
    return l;
  endfunction

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic apply(int d, bit p, bit h, bit x, bit rs);
    @(posedge clk); #1;
    divider = 8'(d); psc_sel = p; half_mode = h; clk_is_xtal = x; restart = rs;
    if (rs) begin base = cyc + 1; cur_len = etu_len(d, p, h, x); end
    @(posedge clk); #1;
    restart = 0;
  endtask

  task automatic push_periods(int n, string req);
    for (int m = 0; m < n; m++) begin
      int h = cur_len / 2;
      if (h > 0) begin q_cyc.push_back(base + h - 1); q_etu.push_back(0); q_req.push_back(req); end
      q_cyc.push_back(base + cur_len - 1); q_etu.push_back(1); q_req.push_back(req);
      base += cur_len;
    end
    while (cyc < base) begin @(posedge clk); #1; end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        check(0, {q_req[0], " missed tick"}, cyc, q_cyc[0]);
        void'(q_cyc.pop_front()); void'(q_etu.pop_front()); void'(q_req.pop_front());
      end
      if (etu_tick || half_tick) begin
        ticks_seen++;
        if (q_cyc.size() == 0) check(0, "R5/R10 unexpected tick", cyc, -1);
        else begin
          check(q_cyc[0] == cyc && q_etu[0] == etu_tick && (etu_tick != half_tick),
                {q_req[0], q_etu[0] ? " etu_tick" : " half_tick"}, cyc, q_cyc[0]);
          void'(q_cyc.pop_front()); void'(q_etu.pop_front()); void'(q_req.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(etu_tick == 0 && half_tick == 0, "R1 reset outputs", etu_tick + half_tick, 0);

    begin
      int seen0 = ticks_seen;
      step(40);
      check(ticks_seen == seen0, "R5 idle with divider 0", ticks_seen - seen0, 0);
    end

    apply(1, 0, 0, 0, 0);
    base = cyc; cur_len = 31;
    push_periods(2, "R6 idle load / R2 P=31 D=1");

    apply(4, 1, 0, 0, 1); push_periods(2, "R2 P=32 D=4");
    apply(7, 0, 0, 0, 1); push_periods(2, "R2 P=31 D=7");
    apply(3, 1, 1, 0, 1); push_periods(2, "R3 half P=32 D=3");
    apply(5, 0, 1, 0, 1); push_periods(2, "R3 R8 half odd P=31 D=5");
    apply(3, 1, 1, 1, 1); push_periods(2, "R4 xtal ignores half");
    apply(255, 1, 1, 0, 1); push_periods(1, "R3 max divider half");

    apply(2, 0, 0, 0, 1);
    step(10);
    divider = 8'd3;
    push_periods(1, "R6 old length kept");
    cur_len = 93;
    push_periods(2, "R6 new length after boundary");

    apply(2, 0, 0, 0, 1);
    step(20);
    apply(2, 0, 0, 0, 1);
    push_periods(1, "R7 restart mid-period");

    apply(2, 0, 0, 0, 1);
    step(9);
    clk_en = 0;
    step(7);
    clk_en = 1;
    base += 7;
    push_periods(2, "R9 enable freeze");

    begin
      int seen0;
      apply(0, 0, 0, 0, 1);
      seen0 = ticks_seen;
      step(60);
      check(ticks_seen == seen0, "R5 divider 0 after restart", ticks_seen - seen0, 0);
    end

    check(q_cyc.size() == 0, "R8 all expected ticks seen", q_cyc.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      check(0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule